// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port whose pins can each be handed to an on-chip serial peripheral (SPI or UART). Software sees two 8-bit registers on a simple register bus: an output latch and a direction register. Each pin has a tri-state driver, made of an output value and an output-enable, and an input path. The input path passes through a two-flop synchroniser before it is read back.

Each pin also has a peripheral-enable input. When it is asserted on a shareable pin, the peripheral's own value and output-enable take over that pin's driver. A write to the latch still updates the stored value, but it leaves the pad alone until the peripheral lets the pin go. The bit order matches the serial functions wired to the port. From bit 7 down to bit 0 they are: SPI slave select, SPI clock, SPI master-out data, SPI master-in data, two GPIO-only bits, UART transmit and UART receive.

Top module: `pin_share_port`

## Requirements
- R1: After reset the direction register and the output latch are both 0x00, so every `pad_oe` bit is 0 and every pin is an input.
- R2: The direction register sits at bus offset 0x01. A write there takes effect on the clock edge on which `bus_wr` is high, and a read returns the stored value. Bit value 1 makes a pin an output and 0 makes it an input.
- R3: A write at offset 0x00 always stores `bus_wdata` in the output latch. On a pin not owned by a peripheral, `pad_out` equals the latch bit and `pad_oe` equals the direction bit.
- R4: A read at offset 0x00 returns, for each pin whose direction bit is 0, the pad level seen two clock edges earlier. The pad level passes through a two-flop synchroniser.
- R5: A read at offset 0x00 returns, for each pin whose direction bit is 1, the value currently on that pin's `pad_out`.
- R6: On a shareable pin with `periph_en` high, `pad_out` follows `periph_out` and `pad_oe` follows `periph_oe`, whatever the direction bit is. A data-register write does not change that pin's pad.
- R7: Bits 3 and 2 are never shared. Their `periph_en`, `periph_out` and `periph_oe` inputs have no effect on the pads.
- R8: A latch value written while a peripheral owns a pin appears on `pad_out` as soon as `periph_en` for that pin drops, provided its direction bit is 1.
- R9: A write to any offset other than 0x00 and 0x01 changes neither register, and a read there returns 0x00.
- R10: Reads are combinational: `bus_rdata` reflects `bus_addr` and the current state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad driver values |
| pad_oe | output | 8 | Pad driver enables, 1 = drive |
| periph_en | input | 8 | Per-pin peripheral ownership request |
| periph_out | input | 8 | Per-pin peripheral output value |
| periph_oe | input | 8 | Per-pin peripheral output-enable |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are known whenever `bus_wr` is high. They also assume that peripheral inputs change only between clock edges, so an owned pad's history can be compared with the peripheral value's history. The pad-hold check applies only when a pin stays owned and its peripheral value holds still across the cycle. The bench keeps within these limits by driving every input on the falling clock edge, never overlapping a bus write with a change of ownership, and holding `periph_out` steady during each data-register write it checks against an owned pin.

// File: rtl/port_pkg.sv
package port_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned OFS_W   = 4;
  // bit 3 and bit 2 are GPIO-only
  localparam logic [PORT_W-1:0] SHARE_MASK = 8'b1111_0011;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rst_release.sv
module rst_release (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

  a_r4_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> meta_q == $past(async_in));
  a_r4_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sync_q == $past(meta_q));
endmodule

// File: rtl/port_regs.sv
module port_regs
  import port_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  logic         latch_en;
  logic         dir_en;
  logic [W-1:0] latch_d;
  logic [W-1:0] dir_d;

  always_comb begin
    latch_en = wr && (sel == SEL_DATA);
    dir_en   = wr && (sel == SEL_DIR);
    latch_d  = latch_en ? wdata : latch_q;
    dir_d    = dir_en   ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> dir_q == $past(wdata));
  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DATA) |=> latch_q == $past(wdata));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel != SEL_NONE) |=> ($stable(dir_q) && $stable(latch_q)));
endmodule

// File: rtl/pin_mux.sv
module pin_mux #(
  parameter int unsigned     W     = 8,
  parameter logic [W-1:0]    SHARE = '1
) (
  input  logic [W-1:0] latch,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] p_en,
  input  logic [W-1:0] p_out,
  input  logic [W-1:0] p_oe,
  output logic [W-1:0] drv_out,
  output logic [W-1:0] drv_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (SHARE[i]) begin : g_shared
      always_comb begin
        drv_out[i] = p_en[i] ? p_out[i] : latch[i];
        drv_oe[i]  = p_en[i] ? p_oe[i]  : dir[i];
      end
    end else begin : g_plain
      always_comb begin
        drv_out[i] = latch[i];
        drv_oe[i]  = dir[i];
      end
    end
  end
endmodule

// File: rtl/pin_share_port.sv
module pin_share_port
  import port_pkg::*;
#(
  parameter int unsigned        W          = PORT_W,
  parameter int unsigned        AW         = OFS_W,
  parameter logic [AW-1:0]      DATA_OFS   = 4'h0,
  parameter logic [AW-1:0]      DIR_OFS    = 4'h1,
  parameter logic [W-1:0]       SHARE_BITS = SHARE_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic [W-1:0]  periph_en,
  input  logic [W-1:0]  periph_out,
  input  logic [W-1:0]  periph_oe
);
  logic         rst_n_s;
  reg_sel_e     sel;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_sync;
  logic [W-1:0] owned;

  rst_release u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    if (bus_addr == DATA_OFS)     sel = SEL_DATA;
    else if (bus_addr == DIR_OFS) sel = SEL_DIR;
    else                          sel = SEL_NONE;
  end

  port_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr      (bus_wr),
    .sel     (sel),
    .wdata   (bus_wdata),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  pad_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  pin_mux #(.W(W), .SHARE(SHARE_BITS)) u_mux (
    .latch   (latch_q),
    .dir     (dir_q),
    .p_en    (periph_en),
    .p_out   (periph_out),
    .p_oe    (periph_oe),
    .drv_out (pad_out),
    .drv_oe  (pad_oe)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = (dir_q & pad_out) | (~dir_q & pin_sync);
      SEL_DIR:  bus_rdata = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign owned = periph_en & SHARE_BITS;

  a_r1_reset_inputs: assert property (@(posedge clk)
    $rose(rst_n_s) |-> (dir_q == '0 && latch_q == '0));
  a_r6_owned_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |->
      (((pad_out ^ $past(pad_out)) & owned & $past(owned)
        & ~(periph_out ^ $past(periph_out))) == '0));
  a_r6_owned_enable: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((pad_oe ^ periph_oe) & owned) == '0);
  a_r7_plain_bits: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((pad_oe ^ dir_q) & ~SHARE_BITS) == '0 && ((pad_out ^ latch_q) & ~SHARE_BITS) == '0);
endmodule

// File: tb/sim_pin_share_port.sv
`timescale 1ns/1ps
module sim_pin_share_port;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] periph_en;
  logic [7:0] periph_out;
  logic [7:0] periph_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [7:0] SHARED = 8'hF3;

  pin_share_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_en(periph_en),
    .periph_out(periph_out), .periph_oe(periph_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_out(logic [7:0] en, logic [7:0] po, logic [7:0] lat);
    logic [7:0] own = en & SHARED;
    return (own & po) | (~own & lat);
  endfunction

  function automatic logic [7:0] exp_oe(logic [7:0] en, logic [7:0] poe, logic [7:0] dir);
    logic [7:0] own = en & SHARED;
    return (own & poe) | (~own & dir);
  endfunction

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] lat;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; periph_en = '0; periph_out = '0; periph_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    rd(4'h1, r); check("R1 dir", r, 8'h00);
    wr(4'h1, 8'hFF);
    rd(4'h0, r); check("R1 latch", r, 8'h00);
    wr(4'h1, 8'h00);

    // R2 R3 R4 R5 R10: sweep all direction values, no peripheral ownership
    for (int d = 0; d < 256; d++) begin
      logic [7:0] pin;
      lat = 8'(d * 37 + 11);
      pin = 8'(d ^ 8'h5A);
      wr(4'h1, 8'(d));
      wr(4'h0, lat);
      pad_in = pin;
      @(negedge clk); @(negedge clk);
      rd(4'h1, r); check("R2 dir readback", r, 8'(d));
      check("R3 pad_out", pad_out, lat);
      check("R3 pad_oe", pad_oe, 8'(d));
      rd(4'h0, r); check("R4/R5 data read", r, (8'(d) & lat) | (~8'(d) & pin));
    end

    // R4: two-edge latency of the input path
    wr(4'h1, 8'h00);
    pad_in = 8'h00; @(negedge clk); @(negedge clk);
    pad_in = 8'hA5; @(negedge clk);
    rd(4'h0, r); check("R4 one edge", r, 8'h00);
    @(negedge clk);
    rd(4'h0, r); check("R4 two edges", r, 8'hA5);

    // R6 R7: sweep ownership patterns
    for (int e = 0; e < 256; e++) begin
      logic [7:0] dir = 8'(e * 13 + 5);
      lat = 8'(e * 91 + 3);
      wr(4'h1, dir);
      wr(4'h0, lat);
      periph_en = 8'(e); periph_out = 8'(~e * 7); periph_oe = 8'(e ^ 8'h3C);
      #1;
      check("R6/R7 pad_out", pad_out, exp_out(8'(e), periph_out, lat));
      check("R6/R7 pad_oe", pad_oe, exp_oe(8'(e), periph_oe, dir));
      rd(4'h0, r);
      check("R5 owned readback", r, (dir & exp_out(8'(e), periph_out, lat)) | (~dir & pad_in));
      // R6: data write while owned leaves owned pads alone
      wr(4'h0, ~lat);
      check("R6 write hold", pad_out, exp_out(8'(e), periph_out, ~lat));
      periph_en = '0; periph_oe = '0;
    end

    // R8: latch written under ownership shows after release
    wr(4'h1, 8'h80);
    wr(4'h0, 8'h00);
    periph_en = 8'h80; periph_out = 8'h00; periph_oe = 8'h80;
    wr(4'h0, 8'h80);
    check("R8 while owned", pad_out & 8'h80, 8'h00);
    @(negedge clk); periph_en = 8'h00; #1;
    check("R8 after release", pad_out & 8'h80, 8'h80);

    // R7: unshared bits ignore peripheral inputs entirely
    wr(4'h1, 8'h00); wr(4'h0, 8'h00);
    periph_en = 8'h0C; periph_out = 8'h0C; periph_oe = 8'h0C; #1;
    check("R7 out", pad_out & 8'h0C, 8'h00);
    check("R7 oe", pad_oe & 8'h0C, 8'h00);
    periph_en = '0; periph_out = '0; periph_oe = '0;

    // R9: unmapped offsets
    wr(4'h1, 8'h3C); wr(4'h0, 8'hC3);
    for (int a = 2; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rd(4'(a), r); check("R9 read zero", r, 8'h00);
    end
    rd(4'h1, r); check("R9 dir kept", r, 8'h3C);
    check("R9 latch kept", pad_out, 8'hC3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule